// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into a stream of column addresses, one per clock, in the beat order a DDR2-class memory device uses. A mode word, written through its own strobe and held in a small register, selects the burst length (4 or 8 beats) and the ordering (sequential or interleaved). A start pulse captures the starting column and the current mode. From the next cycle on, the block drives one address per beat, with a valid flag on every beat and a last flag on the final beat.

Sequential ordering for a length-8 burst is nibble-based. The two low address bits rotate upward modulo 4 within the starting group of four. Bit 2 then flips and the same rotation repeats in the other group. Interleaved ordering XORs the beat index into the burst field. Column bits above the burst field are carried through unchanged.

A request that lands on the final beat of a burst is accepted seamlessly. A request that arrives earlier is dropped and reported with a one-cycle error pulse. A running burst cannot be stopped.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-high reset clears any burst in progress, so that `col_valid`, `col_last` and `start_err` are low in the cycle after reset. Reset also loads the mode register with length 4 and sequential order, so a burst started with no prior mode write runs 4 sequential beats.
- R2: The mode word field [2:0] selects the burst length: 3'b010 selects 4 beats and 3'b011 selects 8 beats. Bit 3 selects the order: 0 is sequential and 1 is interleaved. A write whose field [2:0] holds any other code is ignored as a whole, and the mode keeps its previous value.
- R3: A start sampled at a rising edge when the block is idle gives beat 0 in the following cycle. After that, `col_valid` is high on each of exactly 4 or 8 consecutive cycles, and `col_last` is high only on the final beat. There is no way to end a burst early.
- R4: In sequential order at length 4, beat n carries low bits (start[1:0] + n) mod 4, with bit 2 held at its start value (for example, start 3 gives 3,0,1,2).
- R5: In sequential order at length 8, beats 0 to 3 follow the R4 rotation with bit 2 equal to start[2]. Beats 4 to 7 repeat that rotation with bit 2 inverted (for example, start 5 gives 5,6,7,4,1,2,3,0).
- R6: In interleaved order, beat n carries the start address XOR n, applied to bits [1:0] at length 4 and to bits [2:0] at length 8 (for example, start 5 at length 8 gives 5,4,7,6,1,0,3,2).
- R7: Column bits above bit 2 equal those of the captured start column on every beat.
- R8: A start sampled on the edge that ends a final beat is accepted. Its beat 0 follows in the next cycle with no idle cycle.
- R9: A start sampled while a burst is running and its current beat is not the last is ignored. `start_err` pulses high for one cycle in the following cycle, and the running burst continues unchanged.
- R10: A burst uses the mode held in the register at the edge it is accepted. A mode write during a burst, or on the same edge as the start, applies only from the next burst onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_wr | input | 1 | Strobe to write the mode register |
| mode_word | input | MODE_W | Mode word: [2:0] length code, [3] order |
| start | input | 1 | Burst request |
| start_col | input | COL_W | Starting column address |
| col_out | output | COL_W | Column address of the current beat (meaningful while `col_valid`) |
| col_valid | output | 1 | High on every beat of a burst |
| col_last | output | 1 | High on the final beat |
| start_err | output | 1 | One-cycle pulse for a rejected start |

## Verification
Each result is due exactly one edge after the stimulus that causes it. A start, an error pulse and the first beat all follow the sampling edge by one cycle, and every later beat advances by one cycle per edge. A mode write becomes visible only through the next accepted burst. The bench drives inputs on the falling edge. At the rising edge it advances a reference state built from the requirements, and it compares every output on the following falling edge, so each comparison meets the single register stage between input and output. Beat counts per burst are taken from the observed `col_valid` and `col_last` stream to check lengths, seamless joins and late mode writes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef enum logic {
        LEN_4 = 1'b0,
        LEN_8 = 1'b1
    } blen_e;

    typedef struct packed {
        blen_e  len;
        order_e ord;
    } mode_t;

    localparam logic [2:0] LEN4_CODE = 3'b010;
    localparam logic [2:0] LEN8_CODE = 3'b011;
    localparam int         ORD_BIT   = 3;
    localparam int         BEAT_W    = 3;

    localparam mode_t MODE_RESET = '{len: LEN_4, ord: ORD_SEQ};

    function automatic logic [BEAT_W-1:0] final_beat(input blen_e len);
        return (len == LEN_8) ? 3'd7 : 3'd3;
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_seq_pkg::*;
#(
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [MODE_W-1:0] word_i,
    output mode_t             mode_o
);

    typedef struct packed {
        mode_t mode;
    } mreg_t;

    mreg_t st_d, st_q;
    logic  code_ok;

    always_comb begin
        st_d    = st_q;
        code_ok = (word_i[2:0] == LEN4_CODE) || (word_i[2:0] == LEN8_CODE);
        if (wr_i && code_ok) begin
            st_d.mode.len = (word_i[2:0] == LEN8_CODE) ? LEN_8 : LEN_4;
            st_d.mode.ord = word_i[ORD_BIT] ? ORD_ILV : ORD_SEQ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    // R2: an unrecognised length code leaves the register untouched
    p_bad_code_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (word_i[2:0] != LEN4_CODE) && (word_i[2:0] != LEN8_CODE))
        |=> $stable(mode_o));

    // R1: reset leaves length 4, sequential
    p_reset_mode_r1: assert property (@(posedge clk)
        $past(rst) |-> (mode_o == MODE_RESET));

endmodule

// File: rtl/burst_beat_addr.sv
module burst_beat_addr
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  mode_t             mode_i,
    output logic [COL_W-1:0]  addr_o
);

    logic [1:0] low_bits;
    logic       nib_bit;

    always_comb begin
        if (mode_i.ord == ORD_ILV) begin
            low_bits = base_i[1:0] ^ beat_i[1:0];
        end else begin
            low_bits = base_i[1:0] + beat_i[1:0];
        end
        if (mode_i.len == LEN_8) begin
            nib_bit = base_i[2] ^ beat_i[2];
        end else begin
            nib_bit = base_i[2];
        end
    end

    assign addr_o[2:0] = {nib_bit, low_bits};

    generate
        if (COL_W > 3) begin : g_upper
            assign addr_o[COL_W-1:3] = base_i[COL_W-1:3];
        end
    endgenerate

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  mode_t             mode_i,
    output logic              busy_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic [COL_W-1:0]  base_o,
    output mode_t             mode_o,
    output logic              last_o,
    output logic              err_o
);

    typedef struct packed {
        logic              busy;
        logic [BEAT_W-1:0] beat;
        logic [COL_W-1:0]  base;
        mode_t             mode;
        logic              err;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  last_c;
    logic  accept_c;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        last_c   = st_q.busy && (st_q.beat == final_beat(st_q.mode.len));
        accept_c = start_i && (!st_q.busy || last_c);

        if (accept_c) begin
            st_d.busy = 1'b1;
            st_d.beat = '0;
            st_d.base = start_col_i;
            st_d.mode = mode_i;
        end else if (st_q.busy) begin
            if (last_c) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end

        if (start_i && st_q.busy && !last_c) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy <= 1'b0;
            st_q.beat <= '0;
            st_q.base <= '0;
            st_q.mode <= MODE_RESET;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign beat_o = st_q.beat;
    assign base_o = st_q.base;
    assign mode_o = st_q.mode;
    assign last_o = last_c;
    assign err_o  = st_q.err;

    // R3: a burst not on its last beat always advances by one beat
    p_no_stop_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !last_o) |=> (busy_o && (beat_o == $past(beat_o) + 3'd1)));

    // R8: start on the final beat restarts at beat 0 next cycle
    p_seamless_r8: assert property (@(posedge clk) disable iff (rst)
        (last_o && start_i) |=> (busy_o && (beat_o == '0)));

    // R9: an error pulse means the running burst simply moved on
    p_err_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (busy_o && (beat_o != '0)));

    // R10: captured base and mode stay fixed within a burst
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !last_o) |=> ($stable(mode_o) && $stable(base_o)));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last,
    output logic              start_err
);

    mode_t             mode_reg_w;
    mode_t             burst_mode_w;
    logic              busy_w;
    logic [BEAT_W-1:0] beat_w;
    logic [COL_W-1:0]  base_w;
    logic              last_w;
    logic              err_w;

    burst_mode_reg #(.MODE_W(MODE_W)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (mode_wr),
        .word_i (mode_word),
        .mode_o (mode_reg_w)
    );

    burst_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .start_col_i (start_col),
        .mode_i      (mode_reg_w),
        .busy_o      (busy_w),
        .beat_o      (beat_w),
        .base_o      (base_w),
        .mode_o      (burst_mode_w),
        .last_o      (last_w),
        .err_o       (err_w)
    );

    burst_beat_addr #(.COL_W(COL_W)) u_addr (
        .base_i (base_w),
        .beat_i (beat_w),
        .mode_i (burst_mode_w),
        .addr_o (col_out)
    );

    assign col_valid = busy_w;
    assign col_last  = last_w;
    assign start_err = err_w;

    // R3: the last flag only appears on a valid beat
    p_last_valid_r3: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    // R7: upper column bits stay put from beat to beat
    p_upper_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last) |=> (col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

    // R4: a length-4 burst never changes bit 2
    p_nibble_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last && (burst_mode_w.len == LEN_4))
        |=> (col_out[2] == $past(col_out[2])));

    // R9: error pulses last a single cycle
    p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        start_err |=> (!start_err || $past(start)));

endmodule

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;

    localparam int COL_W  = 12;
    localparam int MODE_W = 13;

    logic              clk = 1'b0;
    logic              rst;
    logic              mode_wr;
    logic [MODE_W-1:0] mode_word;
    logic              start;
    logic [COL_W-1:0]  start_col;
    logic [COL_W-1:0]  col_out;
    logic              col_valid;
    logic              col_last;
    logic              start_err;

    int checks = 0;
    int errors = 0;

    // reference state
    bit        m_mlen8, m_milv;
    bit        m_busy, m_len8, m_ilv, m_err;
    int        m_beat;
    bit [11:0] m_base;

    // observed burst lengths
    bit prev_valid = 0, prev_last = 0;
    int obs_cnt = 0;
    int last_len = 0;

    always #4 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .MODE_W(MODE_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode_wr   (mode_wr),
        .mode_word (mode_word),
        .start     (start),
        .start_col (start_col),
        .col_out   (col_out),
        .col_valid (col_valid),
        .col_last  (col_last),
        .start_err (start_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit [11:0] exp_col(bit [11:0] b, int n, bit len8, bit ilv);
        int off;
        if (ilv) off = (int'(b) & 7) ^ n;
        else     off = ((int'(b) & 4) ^ (n & 4)) | ((int'(b) + n) & 3);
        if (!len8) off = (off & 3) | (int'(b) & 4);
        return {b[11:3], off[2:0]};
    endfunction

    task automatic model_edge();
        bit lst, new_err;
        if (rst) begin
            m_busy = 0; m_mlen8 = 0; m_milv = 0; m_err = 0; m_beat = 0;
            return;
        end
        lst     = m_busy && (m_beat == (m_len8 ? 7 : 3));
        new_err = start && m_busy && !lst;
        if (start && (!m_busy || lst)) begin
            m_busy = 1; m_beat = 0; m_base = start_col;
            m_len8 = m_mlen8; m_ilv = m_milv;
        end else if (m_busy) begin
            if (lst) m_busy = 0;
            else     m_beat++;
        end
        if (mode_wr && (mode_word[2:0] == 3'b010 || mode_word[2:0] == 3'b011)) begin
            m_mlen8 = (mode_word[2:0] == 3'b011);
            m_milv  = mode_word[3];
        end
        m_err = new_err;
    endtask

    task automatic compare();
        bit    exp_last;
        string tag;
        exp_last = m_busy && (m_beat == (m_len8 ? 7 : 3));
        chk(col_valid == m_busy, "R3 valid", col_valid, m_busy);
        chk(col_last == exp_last, "R3 last", col_last, exp_last);
        chk(start_err == m_err, "R9 error pulse", start_err, m_err);
        if (m_busy) begin
            tag = m_ilv ? "R6 interleaved" : (m_len8 ? "R5 sequential x8" : "R4 sequential x4");
            chk(col_out[2:0] == exp_col(m_base, m_beat, m_len8, m_ilv) % 8, tag,
                col_out[2:0], exp_col(m_base, m_beat, m_len8, m_ilv) % 8);
            chk(col_out[11:3] == m_base[11:3], "R7 upper bits", col_out[11:3], m_base[11:3]);
        end
        if (col_valid) begin
            obs_cnt = (prev_last || !prev_valid) ? 1 : obs_cnt + 1;
            if (col_last) last_len = obs_cnt;
        end
        prev_valid = col_valid;
        prev_last  = col_last;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic pulse_start(input bit [11:0] c);
        start = 1; start_col = c;
        tick();
        start = 0;
    endtask

    task automatic write_mode(input bit [12:0] w);
        mode_wr = 1; mode_word = w;
        tick();
        mode_wr = 0;
    endtask

    task automatic finish_burst();
        while (!col_last) tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst = 1; mode_wr = 0; mode_word = '0; start = 0; start_col = '0;
        @(negedge clk);
        repeat (3) tick();
        rst = 0;
        tick();
        chk(col_valid == 0 && start_err == 0, "R1 idle after reset", col_valid, 0);

        // R1: default mode, sequential x4 (start 3 -> 3,0,1,2)
        pulse_start(12'h0A3);
        finish_burst();
        chk(last_len == 4, "R1 default length", last_len, 4);

        // R6: interleaved x8, start 5
        write_mode(13'h00B);
        pulse_start(12'h3C5);
        finish_burst();
        chk(last_len == 8, "R2 length code 011", last_len, 8);

        // R5: sequential x8, start 5
        write_mode(13'h003);
        pulse_start(12'h7F5);
        finish_burst();

        // R2: illegal code ignored, length stays 8
        write_mode(13'h00D);
        pulse_start(12'h012);
        finish_burst();
        chk(last_len == 8, "R2 bad code ignored", last_len, 8);

        // R8: seamless join
        write_mode(13'h002);
        pulse_start(12'h101);
        while (!col_last) tick();
        start = 1; start_col = 12'h206;
        tick();
        start = 0;
        chk(col_valid == 1 && prev_valid, "R8 no idle cycle", col_valid, 1);
        chk(col_out == 12'h206, "R8 new burst beat 0", col_out, 12'h206);
        finish_burst();

        // R9: interruption rejected
        pulse_start(12'h0F2);
        start = 1; start_col = 12'h555;
        tick();
        start = 0;
        chk(start_err == 1, "R9 error raised", start_err, 1);
        finish_burst();
        chk(last_len == 4, "R9 burst unaffected", last_len, 4);

        // R10: mode write during burst
        pulse_start(12'h044);
        write_mode(13'h003);
        finish_burst();
        chk(last_len == 4, "R10 current burst keeps mode", last_len, 4);
        pulse_start(12'h048);
        finish_burst();
        chk(last_len == 8, "R10 next burst uses new mode", last_len, 8);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            start     = (r < 30);
            start_col = 12'($urandom);
            mode_wr   = (($urandom % 100) < 6);
            r = $urandom % 4;
            mode_word = 13'($urandom);
            if (r == 0) mode_word[2:0] = 3'b010;
            else if (r == 1) mode_word[2:0] = 3'b011;
            tick();
        end
        start = 0; mode_wr = 0;
        repeat (10) tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule